// File: doc/BRIEF.md
# Storage Key Reference/Change Updater

This block keeps the reference and change bits of a per-page storage key array current. It runs after an address translation has succeeded. It receives the absolute address, the kind of access (load, store or instruction fetch) and the permission flags that the translation produced. For an address inside installed memory, it reads the key of the 4 KB page from an external synchronous key RAM. It then sets the reference bit, and on a store also the change bit, and writes the key back. It returns the permission flags, adjusted where needed, to the requester.

For a load or a fetch of a page whose change bit is still clear, the returned flags lose write permission. The page therefore stays write-protected, and the first store to it traps, comes back through the unit and records the change. Addresses at or beyond the installed memory size bypass the key RAM completely. A key RAM read that returns an error aborts the update without a write-back. The key is updated whether or not a later stage raises an exception, because the recording does not need to be exact.

Top module: `skey_rc_updater`

## Requirements
- R1: After reset, `busy`, `rsp_valid`, `rsp_err`, `kr_rd_en` and `kr_wr_en` are all low.
- R2: The key RAM index on `kr_addr` is the absolute address shifted right by 12 (the page number of a 4 KB page). This holds for any offset within the page and for the last installed page.
- R3: A request whose address is at or above `MEM_SIZE` produces no key RAM read or write. Its response appears the cycle after acceptance, with flags unchanged and `rsp_err` low.
- R4: An in-range request pulses `kr_rd_en` the cycle after acceptance and holds `busy` high for two cycles. In the cycle after that, the response appears together with the write-back strobe.
- R5: Every written-back key has its reference bit (bit 1) set, for every access type.
- R6: A store (`req_acc` = 01) sets the change bit (bit 0) in the written-back key and returns the flags unchanged.
- R7: For a load (00), a fetch (10) or the reserved code (11, treated as a load), the write flag (bit 1 of the flags) is cleared in the response if the stored change bit was clear. If the change bit was set, the flags pass unchanged.
- R8: Key bits other than the reference and change bits are written back unchanged.
- R9: If `kr_err` is high with the read data, no write-back happens. The response carries `rsp_err` high and the request's flags unchanged, and the stored key is unchanged.
- R10: A request presented while `busy` is high is ignored. It produces no key RAM access, no response and no key change.
- R11: Back-to-back requests to the same page, each accepted as early as possible, each see the key written by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_addr | input | ADDR_W | Absolute address of the access |
| req_acc | input | 2 | Access type: 00 load, 01 store, 10 fetch, 11 treated as load |
| req_flags | input | FLAG_W | Permission flags in: bit0 read, bit1 write, bit2 execute |
| busy | output | 1 | Read-modify-write in progress |
| kr_rd_en | output | 1 | Key RAM read strobe |
| kr_wr_en | output | 1 | Key RAM write strobe |
| kr_addr | output | ADDR_W-PAGE_SHIFT | Key RAM index (page number) |
| kr_wdata | output | KEY_W | Key written back |
| kr_rdata | input | KEY_W | Key read data, valid the cycle after `kr_rd_en` |
| kr_err | input | 1 | Key RAM error, qualifies `kr_rdata` |
| rsp_valid | output | 1 | Response strobe |
| rsp_flags | output | FLAG_W | Adjusted permission flags |
| rsp_err | output | 1 | Update aborted by a key RAM error |

## Verification
The assertions check, on every cycle, the protocol of the key RAM port. A read is never repeated in the next cycle, and it is followed by busy. A write-back always carries the reference bit and coincides with a clean response. An error response never writes. The index holds steady from read to write. A read only starts from idle. The bench's scenarios are needed for the data relations: which page index a given address selects, the change bit set on stores, the write flag removed on clean-page loads and fetches, the bypass of out-of-range addresses and its one-cycle latency, the key left intact after an error or an ignored request, and the chaining of keys across back-to-back requests. The bench checks these against a behavioural key model and compares the final contents of the whole key array.

// File: rtl/skey_pkg.sv
package skey_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_READ  = 2'b01,
    ST_WRITE = 2'b10
  } upd_state_t;
endpackage

// File: rtl/skey_page_decode.sv
module skey_page_decode #(
  parameter int ADDR_W = 32,
  parameter int PAGE_SHIFT = 12,
  parameter logic [ADDR_W:0] MEM_SIZE = 33'h0_0010_0000,
  localparam int IDX_W = ADDR_W - PAGE_SHIFT
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  page_idx,
  output logic              in_range
);
  // Page number is the address with the in-page offset removed.
  assign page_idx = addr[ADDR_W-1:PAGE_SHIFT];
  // Range compare at one extra bit so MEM_SIZE may equal 2**ADDR_W.
  assign in_range = ({1'b0, addr} < MEM_SIZE);
endmodule

// File: rtl/skey_merge.sv
module skey_merge
  import skey_pkg::*;
#(
  parameter int KEY_W = 7,
  parameter int REF_BIT = 1,
  parameter int CHG_BIT = 0,
  parameter int FLAG_W = 3,
  parameter int WR_FLAG = 1
) (
  input  logic [KEY_W-1:0]  key_in,
  input  acc_t              acc,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [KEY_W-1:0]  key_out,
  output logic [FLAG_W-1:0] flags_out
);
  logic is_store;
  assign is_store = (acc == ACC_STORE);

  always_comb begin
    key_out = key_in;
    key_out[REF_BIT] = 1'b1;
    if (is_store) key_out[CHG_BIT] = 1'b1;
  end

  always_comb begin
    flags_out = flags_in;
    // Clean page on a non-store: keep it write-protected so a store traps.
    if (!is_store && !key_in[CHG_BIT]) flags_out[WR_FLAG] = 1'b0;
  end
endmodule

// File: rtl/skey_rc_updater.sv
module skey_rc_updater
  import skey_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_SHIFT = 12,
  parameter logic [ADDR_W:0] MEM_SIZE = 33'h0_0010_0000,
  parameter int KEY_W = 7,
  parameter int REF_BIT = 1,
  parameter int CHG_BIT = 0,
  parameter int FLAG_W = 3,
  parameter int WR_FLAG = 1,
  localparam int IDX_W = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_acc,
  input  logic [FLAG_W-1:0] req_flags,
  output logic              busy,
  output logic              kr_rd_en,
  output logic              kr_wr_en,
  output logic [IDX_W-1:0]  kr_addr,
  output logic [KEY_W-1:0]  kr_wdata,
  input  logic [KEY_W-1:0]  kr_rdata,
  input  logic              kr_err,
  output logic              rsp_valid,
  output logic [FLAG_W-1:0] rsp_flags,
  output logic              rsp_err
);
  upd_state_t        state;
  acc_t              acc_q;
  logic [FLAG_W-1:0] flags_q;
  logic [IDX_W-1:0]  page_idx;
  logic              in_range;
  logic [KEY_W-1:0]  key_new;
  logic [FLAG_W-1:0] flags_new;

  skey_page_decode #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .MEM_SIZE(MEM_SIZE)
  ) u_decode (
    .addr(req_addr), .page_idx(page_idx), .in_range(in_range)
  );

  skey_merge #(
    .KEY_W(KEY_W), .REF_BIT(REF_BIT), .CHG_BIT(CHG_BIT),
    .FLAG_W(FLAG_W), .WR_FLAG(WR_FLAG)
  ) u_merge (
    .key_in(kr_rdata), .acc(acc_q), .flags_in(flags_q),
    .key_out(key_new), .flags_out(flags_new)
  );

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      acc_q     <= ACC_LOAD;
      flags_q   <= '0;
      kr_rd_en  <= 1'b0;
      kr_wr_en  <= 1'b0;
      kr_addr   <= '0;
      kr_wdata  <= '0;
      rsp_valid <= 1'b0;
      rsp_flags <= '0;
      rsp_err   <= 1'b0;
    end else begin
      kr_rd_en  <= 1'b0;
      kr_wr_en  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            acc_q   <= acc_t'(req_acc);
            flags_q <= req_flags;
            if (in_range) begin
              kr_addr  <= page_idx;
              kr_rd_en <= 1'b1;
              state    <= ST_READ;
            end else begin
              rsp_valid <= 1'b1;
              rsp_flags <= req_flags;
            end
          end
        end
        ST_READ: state <= ST_WRITE;
        ST_WRITE: begin
          state     <= ST_IDLE;
          rsp_valid <= 1'b1;
          if (kr_err) begin
            rsp_err   <= 1'b1;
            rsp_flags <= flags_q;
          end else begin
            kr_wr_en  <= 1'b1;
            kr_wdata  <= key_new;
            rsp_flags <= flags_new;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/skey_rc_updater_chk.sv
module skey_rc_updater_chk #(
  parameter int IDX_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             kr_rd_en,
  input logic             kr_wr_en,
  input logic [IDX_W-1:0] kr_addr,
  input logic             wr_ref,
  input logic             rsp_valid,
  input logic             rsp_err
);
  // R4
  rd_then_busy_chk: assert property (@(posedge clk) disable iff (rst)
    kr_rd_en |=> (busy && !kr_rd_en));
  // R4
  wr_with_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    kr_wr_en |-> (rsp_valid && !rsp_err));
  // R4
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({kr_rd_en, kr_wr_en}));
  // R5
  ref_set_chk: assert property (@(posedge clk) disable iff (rst)
    kr_wr_en |-> wr_ref);
  // R9
  err_no_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> !kr_wr_en);
  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    kr_wr_en |-> $stable(kr_addr));
  // R10
  rd_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
    kr_rd_en |-> !$past(busy));
endmodule

bind skey_rc_updater skey_rc_updater_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .kr_rd_en(kr_rd_en),
  .kr_wr_en(kr_wr_en), .kr_addr(kr_addr), .wr_ref(kr_wdata[REF_BIT]),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err)
);

// File: tb/skey_rc_updater_tb.sv
module skey_rc_updater_tb;
  localparam int CLK_P = 10;
  localparam int NPG = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0] req_acc = '0;
  logic [2:0] req_flags = '0;
  logic busy, kr_rd_en, kr_wr_en, rsp_valid, rsp_err;
  logic [19:0] kr_addr;
  logic [6:0] kr_wdata;
  logic [6:0] kr_rdata;
  logic kr_err;
  logic [2:0] rsp_flags;

  always #(CLK_P/2) clk = ~clk;

  skey_rc_updater u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_acc(req_acc), .req_flags(req_flags), .busy(busy),
    .kr_rd_en(kr_rd_en), .kr_wr_en(kr_wr_en), .kr_addr(kr_addr),
    .kr_wdata(kr_wdata), .kr_rdata(kr_rdata), .kr_err(kr_err),
    .rsp_valid(rsp_valid), .rsp_flags(rsp_flags), .rsp_err(rsp_err)
  );

  function automatic logic [6:0] init_key(int i);
    // upper bits vary, reference clear, change bit = page bit 1
    return {i[3:0] ^ 4'h5, i[0], 1'b0, i[1]};
  endfunction

  // key RAM model
  logic [6:0] mem [NPG];
  bit errpg [NPG];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPG; i++) mem[i] <= init_key(i);
      kr_rdata <= '0;
      kr_err <= 1'b0;
    end else begin
      if (kr_wr_en) mem[kr_addr[7:0]] <= kr_wdata;
      if (kr_rd_en) begin
        kr_rdata <= mem[kr_addr[7:0]];
        kr_err <= errpg[kr_addr[7:0]];
      end
    end
  end

  // reference model state
  logic [6:0] gkey [NPG];
  int cyc = 0;
  int free_c = 0;
  int bz_lo = -10, bz_hi = -10;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int q_c[$]; logic [2:0] q_f[$]; bit q_e[$]; bit q_w[$];
  logic [6:0] q_k[$]; string q_t[$];
  int r_c[$]; logic [19:0] r_i[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(busy == (cyc >= bz_lo && cyc <= bz_hi), "R4", "busy", busy, 0);
      if (r_c.size() > 0 && r_c[0] == cyc) begin
        chk(kr_rd_en == 1'b1, "R4", "read strobe", kr_rd_en, 1);
        chk(kr_addr == r_i[0], "R2", "key index", kr_addr, r_i[0]);
        void'(r_c.pop_front()); void'(r_i.pop_front());
      end else begin
        chk(kr_rd_en == 1'b0, "R10", "unexpected read", kr_rd_en, 0);
      end
      if (q_c.size() > 0 && q_c[0] == cyc) begin
        chk(rsp_valid == 1'b1, q_t[0], "rsp_valid", rsp_valid, 1);
        chk(rsp_flags == q_f[0], q_t[0], "rsp_flags", rsp_flags, q_f[0]);
        chk(rsp_err == q_e[0], q_t[0], "rsp_err", rsp_err, q_e[0]);
        chk(kr_wr_en == q_w[0], q_t[0], "write strobe", kr_wr_en, q_w[0]);
        if (q_w[0]) chk(kr_wdata == q_k[0], q_t[0], "written key", kr_wdata, q_k[0]);
        void'(q_c.pop_front()); void'(q_f.pop_front()); void'(q_e.pop_front());
        void'(q_w.pop_front()); void'(q_k.pop_front()); void'(q_t.pop_front());
      end else begin
        chk(rsp_valid == 1'b0, "R10", "unexpected response", rsp_valid, 0);
        chk(kr_wr_en == 1'b0, "R10", "unexpected write", kr_wr_en, 0);
      end
    end
  end

  task automatic issue(logic [31:0] a, logic [1:0] acc, logic [2:0] f,
                       string tag, bit force_now);
    int c;
    int idx;
    logic [6:0] k, nk;
    logic [2:0] nf;
    @(negedge clk); #1;
    if (!force_now) while (cyc + 1 < free_c) begin @(negedge clk); #1; end
    req_valid = 1'b1; req_addr = a; req_acc = acc; req_flags = f;
    c = cyc + 1;
    if (c >= free_c) begin
      if ({1'b0, a} >= 33'h0_0010_0000) begin
        q_c.push_back(c); q_f.push_back(f); q_e.push_back(0);
        q_w.push_back(0); q_k.push_back('0); q_t.push_back(tag);
        free_c = c + 1;
      end else begin
        idx = int'(a >> 12);
        r_c.push_back(c); r_i.push_back(20'(idx));
        bz_lo = c; bz_hi = c + 1;
        k = gkey[idx];
        if (errpg[idx]) begin
          q_c.push_back(c + 2); q_f.push_back(f); q_e.push_back(1);
          q_w.push_back(0); q_k.push_back('0); q_t.push_back(tag);
        end else begin
          nk = k | 7'b0000010;
          if (acc == 2'b01) nk = nk | 7'b0000001;
          nf = f;
          if (acc != 2'b01 && !k[0]) nf[1] = 1'b0;
          gkey[idx] = nk;
          q_c.push_back(c + 2); q_f.push_back(nf); q_e.push_back(0);
          q_w.push_back(1); q_k.push_back(nk); q_t.push_back(tag);
        end
        free_c = c + 3;
      end
    end
    @(negedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NPG; i++) begin gkey[i] = init_key(i); errpg[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1", "busy", busy, 0);
    chk(rsp_valid == 0 && rsp_err == 0, "R1", "rsp", rsp_valid, 0);
    chk(kr_rd_en == 0 && kr_wr_en == 0, "R1", "key strobes", kr_rd_en, 0);
    free_c = cyc + 1;

    // R7 R5: load of a clean page drops write permission
    issue(32'h0000_4000, 2'b00, 3'b111, "R7", 0);
    // R6 R11: store right after, same page
    issue(32'h0000_4010, 2'b01, 3'b111, "R6", 0);
    // R11: load now sees change bit set
    issue(32'h0000_4FFC, 2'b00, 3'b111, "R11", 0);
    // R7: fetch of a dirty page keeps flags
    issue(32'h0000_6000, 2'b10, 3'b101, "R7", 0);
    // R7: fetch of a clean page clears write
    issue(32'h0000_8000, 2'b10, 3'b111, "R7", 0);
    // R7: reserved code behaves as a load
    issue(32'h0000_C123, 2'b11, 3'b011, "R7", 0);
    // R8: store keeps the other key bits
    issue(32'h0000_7000, 2'b01, 3'b111, "R8", 0);
    // R2: last installed page and an in-page offset
    issue(32'h000F_FFFF, 2'b01, 3'b101, "R2", 0);
    issue(32'h0000_3ABC, 2'b00, 3'b110, "R2", 0);
    // R3: out-of-range addresses bypass the key RAM
    issue(32'h0010_0000, 2'b00, 3'b110, "R3", 0);
    issue(32'hFFFF_F000, 2'b01, 3'b111, "R3", 0);
    issue(32'h0000_A000, 2'b00, 3'b111, "R3", 0);
    // R9: key RAM error aborts, key untouched
    errpg[9] = 1;
    issue(32'h0000_9000, 2'b01, 3'b111, "R9", 0);
    repeat (4) @(negedge clk);
    errpg[9] = 0;
    issue(32'h0000_9000, 2'b00, 3'b111, "R9", 0);
    // R10: request while busy is ignored
    issue(32'h0000_D000, 2'b00, 3'b111, "R10", 0);
    issue(32'h0000_D000, 2'b01, 3'b111, "R10", 1);
    issue(32'h0000_D000, 2'b00, 3'b111, "R10", 0);
    repeat (6) @(negedge clk);
    chk(q_c.size() == 0 && r_c.size() == 0, "R4", "pending responses", q_c.size(), 0);
    // R8 R5 R6 R9 R10: whole key array against the model
    for (int i = 0; i < NPG; i++)
      chk(mem[i] == gkey[i], "R8", $sformatf("key of page %0d", i), mem[i], gkey[i]);
    finish_run();
  end
endmodule